// File: doc/BRIEF.md
# Dual-Channel Memory Address Mapper

The mapper sits between a system-side request port and two memory channels, each 64 data bits wide. It takes a flat physical byte address and decides which channel serves it. It also works out the address that channel sees. Every access is one 64-byte line, which is a burst of eight beats on a 64-bit channel, so only line-level placement matters. Two organisations can be chosen at run time when both channels are fitted:

- **Stacked**: channel A fills first and channel B carries on at the address just past the last channel A byte.
- **Interleaved**: consecutive lines ping-pong between the two channels.

A single-channel setting sends everything to channel A.

Requests arrive on a valid/ready port. Each accepted request is held in a one-entry slot and offered on exactly one channel's valid/ready port. A new request is accepted in the same cycle the held one is taken, so the mapper keeps full throughput. A request at or beyond the programmed capacity is dropped, and the mapper pulses an error flag for it. Configuration is copied into a working set only while nothing is held, so a held request and the request accepted as it drains are both decoded under the configuration that was in force.

Top module: `chan_addr_mapper`

## Requirements
- R1: After reset both channel valids and `err_oor` are low and `req_ready` is high.
- R2: With `cfg_dual`=0 every in-range request goes to channel A with its address unchanged, whatever `cfg_ilv` holds; the capacity is `cfg_a_size` bytes.
- R3: With `cfg_dual`=1 and `cfg_ilv`=0 (stacked), an address below `cfg_a_size` goes to channel A unchanged, and any other in-range address goes to channel B as the address minus `cfg_a_size`.
- R4: With `cfg_dual`=1 and `cfg_ilv`=1 (interleaved), address bit 6 selects the channel (0 = A, 1 = B), and the channel address is the system address with bit 6 removed, the bits above it moved down one place and a zero placed on top.
- R5: A request whose address is at or above the capacity (`cfg_a_size`, or `cfg_a_size`+`cfg_b_size` in dual modes) raises no channel valid, and `err_oor` is high for exactly the one cycle after its acceptance.
- R6: An accepted in-range request shows up on the selected channel's valid and address in the cycle after acceptance, and the other channel's valid stays low.
- R7: While the selected channel's ready is low, its valid and address hold steady and `req_ready` is low.
- R8: In the cycle a held request is taken by its channel, a new request is accepted, and it appears on its channel in the next cycle.
- R9: Configuration inputs take effect one cycle after they are presented with no request held. While a request is held they are not adopted, so a request accepted in the cycle the held one drains is decoded with the earlier configuration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_dual | input | 1 | 1 when both channels are populated |
| cfg_ilv | input | 1 | 1 selects interleaved, 0 stacked (dual only) |
| cfg_a_size | input | ADDR_W | Channel A capacity in bytes |
| cfg_b_size | input | ADDR_W | Channel B capacity in bytes |
| req_valid | input | 1 | System request valid |
| req_ready | output | 1 | Mapper can take a request |
| req_addr | input | ADDR_W | System byte address |
| cha_valid | output | 1 | Request offered to channel A |
| cha_ready | input | 1 | Channel A takes the request |
| cha_addr | output | ADDR_W | Channel A local address |
| chb_valid | output | 1 | Request offered to channel B |
| chb_ready | input | 1 | Channel B takes the request |
| chb_addr | output | ADDR_W | Channel B local address |
| err_oor | output | 1 | One-cycle pulse for a dropped out-of-range request |

## Verification
The hardest case to reach is a configuration change that lands while a request is held, with a second request accepted in the very cycle the first one drains. The stimulus gets there by stalling channel A's ready and switching from stacked to interleaved during the stall. It keeps a second request waiting on the input, then releases ready. The second request must still follow the stacked layout, and a later request must follow the interleaved one. The bench also steps through boundary addresses just below and at each capacity limit, and drives lines whose bit 6 and higher bits exercise the interleave compaction.

// File: rtl/mem_map_pkg.sv
package mem_map_pkg;

    localparam int NUM_CH = 2;
    localparam int CH_A   = 0;
    localparam int CH_B   = 1;

    typedef enum logic [1:0] {
        MAP_SINGLE  = 2'd0,
        MAP_STACKED = 2'd1,
        MAP_ILV     = 2'd2
    } map_mode_e;

    // Resolve the two configuration bits into one working mode.
    function automatic map_mode_e mode_of(input logic dual, input logic ilv);
        if (!dual)
            return MAP_SINGLE;
        else if (ilv)
            return MAP_ILV;
        else
            return MAP_STACKED;
    endfunction

endpackage

// File: rtl/mapper_cfg.sv
module mapper_cfg
    import mem_map_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              busy,
    input  logic              dual,
    input  logic              ilv,
    input  logic [ADDR_W-1:0] a_size,
    input  logic [ADDR_W-1:0] b_size,
    output map_mode_e         mode_q,
    output logic [ADDR_W-1:0] a_q,
    output logic [ADDR_W-1:0] b_q
);

    // The working copy only follows the inputs while no request is held.
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MAP_SINGLE;
            a_q    <= '0;
            b_q    <= '0;
        end else if (!busy) begin
            mode_q <= mode_of(dual, ilv);
            a_q    <= a_size;
            b_q    <= b_size;
        end
    end

endmodule

// File: rtl/mapper_decode.sv
module mapper_decode
    import mem_map_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int LINE_BITS = 6
) (
    input  map_mode_e         mode,
    input  logic [ADDR_W-1:0] a_size,
    input  logic [ADDR_W-1:0] b_size,
    input  logic [ADDR_W-1:0] addr,
    output logic              sel_b,
    output logic [ADDR_W-1:0] local_addr,
    output logic              oor
);

    localparam int UPPER_W = ADDR_W - LINE_BITS - 1;

    logic [ADDR_W:0]   limit;
    logic              above_a;
    logic [ADDR_W-1:0] squeezed;
    logic [ADDR_W-1:0] rebased;

    always_comb begin
        if (mode == MAP_SINGLE)
            limit = {1'b0, a_size};
        else
            limit = {1'b0, a_size} + {1'b0, b_size};
    end

    assign oor      = ({1'b0, addr} >= limit);
    assign above_a  = (addr >= a_size);
    assign rebased  = addr - a_size;
    assign squeezed = {1'b0, addr[ADDR_W-1 -: UPPER_W], addr[LINE_BITS-1:0]};

    always_comb begin
        unique case (mode)
            MAP_STACKED: begin
                sel_b      = above_a;
                local_addr = above_a ? rebased : addr;
            end
            MAP_ILV: begin
                sel_b      = addr[LINE_BITS];
                local_addr = squeezed;
            end
            default: begin
                sel_b      = 1'b0;
                local_addr = addr;
            end
        endcase
    end

endmodule

// File: rtl/mapper_slot.sv
module mapper_slot
    import mem_map_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              in_sel_b,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic              in_oor,
    input  logic [NUM_CH-1:0] out_ready,
    output logic [NUM_CH-1:0] out_valid,
    output logic [ADDR_W-1:0] out_addr,
    output logic              err,
    output logic              busy
);

    logic              held;
    logic              held_b;
    logic [ADDR_W-1:0] held_addr;
    logic              drain;
    logic              take;

    assign drain    = held && out_ready[held_b ? CH_B : CH_A];
    assign in_ready = !held || drain;
    assign take     = in_valid && in_ready;
    assign busy     = held;
    assign out_addr = held_addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            held      <= 1'b0;
            held_b    <= 1'b0;
            held_addr <= '0;
            err       <= 1'b0;
        end else begin
            err <= take && in_oor;
            if (take && !in_oor) begin
                held      <= 1'b1;
                held_b    <= in_sel_b;
                held_addr <= in_addr;
            end else if (drain) begin
                held <= 1'b0;
            end
        end
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assign out_valid[c] = held && (held_b == (c == CH_B));
    end

endmodule

// File: rtl/chan_addr_mapper.sv
module chan_addr_mapper
    import mem_map_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int LINE_BITS = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_dual,
    input  logic              cfg_ilv,
    input  logic [ADDR_W-1:0] cfg_a_size,
    input  logic [ADDR_W-1:0] cfg_b_size,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              cha_valid,
    input  logic              cha_ready,
    output logic [ADDR_W-1:0] cha_addr,
    output logic              chb_valid,
    input  logic              chb_ready,
    output logic [ADDR_W-1:0] chb_addr,
    output logic              err_oor
);

    map_mode_e         mode_q;
    logic [ADDR_W-1:0] a_q;
    logic [ADDR_W-1:0] b_q;
    logic              busy;
    logic              sel_b;
    logic [ADDR_W-1:0] local_addr;
    logic              oor;
    logic [NUM_CH-1:0] rdy_vec;
    logic [NUM_CH-1:0] vld_vec;
    logic [ADDR_W-1:0] slot_addr;

    mapper_cfg #(.ADDR_W(ADDR_W)) u_cfg (
        .clk    (clk),
        .rst    (rst),
        .busy   (busy),
        .dual   (cfg_dual),
        .ilv    (cfg_ilv),
        .a_size (cfg_a_size),
        .b_size (cfg_b_size),
        .mode_q (mode_q),
        .a_q    (a_q),
        .b_q    (b_q)
    );

    mapper_decode #(.ADDR_W(ADDR_W), .LINE_BITS(LINE_BITS)) u_dec (
        .mode       (mode_q),
        .a_size     (a_q),
        .b_size     (b_q),
        .addr       (req_addr),
        .sel_b      (sel_b),
        .local_addr (local_addr),
        .oor        (oor)
    );

    assign rdy_vec[CH_A] = cha_ready;
    assign rdy_vec[CH_B] = chb_ready;

    mapper_slot #(.ADDR_W(ADDR_W)) u_slot (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (req_valid),
        .in_ready  (req_ready),
        .in_sel_b  (sel_b),
        .in_addr   (local_addr),
        .in_oor    (oor),
        .out_ready (rdy_vec),
        .out_valid (vld_vec),
        .out_addr  (slot_addr),
        .err       (err_oor),
        .busy      (busy)
    );

    assign cha_valid = vld_vec[CH_A];
    assign chb_valid = vld_vec[CH_B];
    assign cha_addr  = slot_addr;
    assign chb_addr  = slot_addr;

endmodule

// File: rtl/chan_addr_mapper_chk.sv
module chan_addr_mapper_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic              cha_valid,
    input logic              cha_ready,
    input logic [ADDR_W-1:0] cha_addr,
    input logic              chb_valid,
    input logic              chb_ready,
    input logic [ADDR_W-1:0] chb_addr,
    input logic              err_oor
);

    AST_ONE_TARGET: assert property (@(posedge clk) disable iff (rst)
        !(cha_valid && chb_valid)); // R6

    AST_ACCEPT_LANDS: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> (cha_valid || chb_valid || err_oor)); // R6

    AST_HOLD_A: assert property (@(posedge clk) disable iff (rst)
        (cha_valid && !cha_ready) |=> (cha_valid && $stable(cha_addr))); // R7

    AST_HOLD_B: assert property (@(posedge clk) disable iff (rst)
        (chb_valid && !chb_ready) |=> (chb_valid && $stable(chb_addr))); // R7

    AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        ((cha_valid && !cha_ready) || (chb_valid && !chb_ready)) |-> !req_ready); // R7

    AST_ERR_NO_FWD: assert property (@(posedge clk) disable iff (rst)
        err_oor |-> (!cha_valid && !chb_valid)); // R5

    AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (rst)
        err_oor |-> $past(req_valid && req_ready)); // R5

    AST_IDLE_READY: assert property (@(posedge clk) disable iff (rst)
        (!cha_valid && !chb_valid) |-> req_ready); // R8

endmodule

bind chan_addr_mapper chan_addr_mapper_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .cha_valid (cha_valid),
    .cha_ready (cha_ready),
    .cha_addr  (cha_addr),
    .chb_valid (chb_valid),
    .chb_ready (chb_ready),
    .chb_addr  (chb_addr),
    .err_oor   (err_oor)
);

// File: tb/sim_chan_addr_mapper.sv
`timescale 1ns/1ps
module sim_chan_addr_mapper;

    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_dual = 1'b0;
    logic          cfg_ilv = 1'b0;
    logic [AW-1:0] cfg_a_size = '0;
    logic [AW-1:0] cfg_b_size = '0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic          cha_valid, chb_valid;
    logic          cha_ready = 1'b1;
    logic          chb_ready = 1'b1;
    logic [AW-1:0] cha_addr, chb_addr;
    logic          err_oor;

    int compared = 0;
    int mismatched = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    chan_addr_mapper #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst(rst),
        .cfg_dual(cfg_dual), .cfg_ilv(cfg_ilv),
        .cfg_a_size(cfg_a_size), .cfg_b_size(cfg_b_size),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .cha_valid(cha_valid), .cha_ready(cha_ready), .cha_addr(cha_addr),
        .chb_valid(chb_valid), .chb_ready(chb_ready), .chb_addr(chb_addr),
        .err_oor(err_oor)
    );

    // exp_to: 0 = channel A, 1 = channel B, 2 = dropped with error
    typedef struct packed {
        logic          dual;
        logic          ilv;
        logic [AW-1:0] a;
        logic [AW-1:0] b;
        logic [AW-1:0] addr;
        logic [1:0]    exp_to;
        logic [AW-1:0] loc;
        logic [3:0]    req;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 1'b0, 32'h1000, 32'h0800, 32'h0040, 2'd0, 32'h0040, 4'd2},
        '{1'b0, 1'b1, 32'h1000, 32'h0800, 32'h0040, 2'd0, 32'h0040, 4'd2},
        '{1'b0, 1'b0, 32'h1000, 32'h0800, 32'h0FFF, 2'd0, 32'h0FFF, 4'd2},
        '{1'b0, 1'b0, 32'h1000, 32'h0800, 32'h1000, 2'd2, 32'h0000, 4'd5},
        '{1'b1, 1'b0, 32'h1000, 32'h0800, 32'h0FFF, 2'd0, 32'h0FFF, 4'd3},
        '{1'b1, 1'b0, 32'h1000, 32'h0800, 32'h1000, 2'd1, 32'h0000, 4'd3},
        '{1'b1, 1'b0, 32'h1000, 32'h0800, 32'h17FF, 2'd1, 32'h07FF, 4'd3},
        '{1'b1, 1'b0, 32'h1000, 32'h0800, 32'h1800, 2'd2, 32'h0000, 4'd5},
        '{1'b1, 1'b1, 32'h1000, 32'h1000, 32'h0000, 2'd0, 32'h0000, 4'd4},
        '{1'b1, 1'b1, 32'h1000, 32'h1000, 32'h0040, 2'd1, 32'h0000, 4'd4},
        '{1'b1, 1'b1, 32'h1000, 32'h1000, 32'h0085, 2'd0, 32'h0045, 4'd4},
        '{1'b1, 1'b1, 32'h1000, 32'h1000, 32'h01C3, 2'd1, 32'h00C3, 4'd4},
        '{1'b1, 1'b1, 32'h1000, 32'h1000, 32'h1FFF, 2'd1, 32'h0FFF, 4'd4},
        '{1'b1, 1'b1, 32'h1000, 32'h1000, 32'h2000, 2'd2, 32'h0000, 4'd5}
    };

    task automatic chk(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic set_cfg(input logic d, input logic i, input logic [AW-1:0] a, input logic [AW-1:0] b);
        cfg_dual = d; cfg_ilv = i; cfg_a_size = a; cfg_b_size = b;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            mismatched++;
            compared++;
            $display("FAIL watchdog actual=%0d expected=<20000 cycles", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: idle state after reset
        chk("R1 cha_valid", {31'b0, cha_valid}, 32'd0);
        chk("R1 chb_valid", {31'b0, chb_valid}, 32'd0);
        chk("R1 err_oor",   {31'b0, err_oor},   32'd0);
        chk("R1 req_ready", {31'b0, req_ready}, 32'd1);

        // Table walk: R2, R3, R4, R5, R6
        for (int k = 0; k < NV; k++) begin
            string t;
            t = $sformatf("R%0d vec%0d", VEC[k].req, k);
            @(negedge clk);
            set_cfg(VEC[k].dual, VEC[k].ilv, VEC[k].a, VEC[k].b);
            @(negedge clk);
            req_valid = 1'b1;
            req_addr  = VEC[k].addr;
            @(negedge clk);
            req_valid = 1'b0;
            chk({t, " cha_valid"}, {31'b0, cha_valid}, {31'b0, VEC[k].exp_to == 2'd0});
            chk({t, " chb_valid"}, {31'b0, chb_valid}, {31'b0, VEC[k].exp_to == 2'd1});
            chk({t, " err_oor"},   {31'b0, err_oor},   {31'b0, VEC[k].exp_to == 2'd2});
            if (VEC[k].exp_to == 2'd0) chk({t, " cha_addr"}, cha_addr, VEC[k].loc);
            if (VEC[k].exp_to == 2'd1) chk({t, " chb_addr"}, chb_addr, VEC[k].loc);
            @(negedge clk);
            if (VEC[k].exp_to == 2'd2)
                chk({"R5 one-cycle pulse ", t}, {31'b0, err_oor}, 32'd0);
        end

        // R7 stall on channel A in stacked mode, then R9 and R8
        @(negedge clk);
        set_cfg(1'b1, 1'b0, 32'h1000, 32'h0800);
        cha_ready = 1'b0;
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = 32'h0100;
        @(negedge clk);
        req_addr  = 32'h0040;
        set_cfg(1'b1, 1'b1, 32'h1000, 32'h1000);
        repeat (3) @(negedge clk);
        chk("R7 held valid",   {31'b0, cha_valid}, 32'd1);
        chk("R7 held addr",    cha_addr, 32'h0100);
        chk("R7 ready low",    {31'b0, req_ready}, 32'd0);
        chk("R6 other idle",   {31'b0, chb_valid}, 32'd0);
        cha_ready = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        // R8: second request taken as the first drained; R9: old stacked layout
        chk("R8 next valid",   {31'b0, cha_valid}, 32'd1);
        chk("R9 old cfg addr", cha_addr, 32'h0040);
        chk("R9 not on B",     {31'b0, chb_valid}, 32'd0);
        repeat (2) @(negedge clk);
        req_valid = 1'b1;
        req_addr  = 32'h0040;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R9 new cfg B",    {31'b0, chb_valid}, 32'd1);
        chk("R9 new cfg addr", chb_addr, 32'h0000);

        // R7 stall on channel B in interleaved mode
        @(negedge clk);
        chb_ready = 1'b0;
        req_valid = 1'b1;
        req_addr  = 32'h00C0;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        chk("R7 B held",       {31'b0, chb_valid}, 32'd1);
        chk("R7 B addr",       chb_addr, 32'h0040);
        chk("R7 B ready low",  {31'b0, req_ready}, 32'd0);
        chk("R6 A idle",       {31'b0, cha_valid}, 32'd0);
        chb_ready = 1'b1;
        @(negedge clk);
        chk("R7 B drained",    {31'b0, chb_valid}, 32'd0);
        chk("R7 ready back",   {31'b0, req_ready}, 32'd1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule